// File: doc/BRIEF.md
# Paged Boot ROM Bank Controller

This block lets a Z80-class home computer see one page of a larger parallel flash or PEROM through its 16kB ROM window. Software selects the page by writing one byte to I/O port 0xD0. The block keeps that byte and uses it, together with a few live inputs, to drive three things: the upper flash address lines, the flash chip-enable and write-enable, and a ROM-disable output to the expansion slot.

The byte has several jobs. It holds the page number and a write-permit bit. It has two bits that swap a flash address line for a live signal: the 128K paging bit, or the opcode-fetch line /M1. /M1 is used so that opcode fetches and data reads in the same window can reach different pages. One more bit chooses between ROM and expansion RAM.

A sticky flag, set by the first port write after reset, keeps the ROM enabled until software has written once. A mode bit in the written byte re-maps the page field so that 32 pages can be used. An external EXROM pin pins the top of a 128kB page group high and passes the CPU's A14/A15 through. The block also drives a line that keeps the video chip from answering the ports at 0xD0–0xD3.

Top module: `rom_pager`

## Requirements
- R1: After reset the stored byte and the sticky flag are both 0. The ROM is enabled (`romDisable`=0), flash lines 18..14 are 0, and `flashWeN` is 1.
- R2: The byte is stored only on a clock edge where `cpuAddr[7:0]`=0xD0, `iorqN`=0 and `wrN`=0. I/O writes to other addresses and I/O reads leave the stored byte unchanged.
- R3: Any accepted port write sets the sticky flag. Only reset clears it. `romDisable` is 1 exactly when stored bit 7 is 0 and the flag is 1.
- R4: `flashWeN` goes low only when all of these hold: `mreqN`=0, `wrN`=0, the ROM is enabled, and stored bit 4 is 1.
- R5: In 8-page mode with EXROM low and stored bit 5 set, flash line 14 equals `pageBit128`. With bit 5 clear, flash line 14 equals stored bit 0.
- R6: In 8-page mode with EXROM low and stored bit 6 set, flash line 15 equals `m1N`. With bit 6 clear, flash line 15 equals stored bit 1.
- R7: With `exromMode`=1, flash line 16 is 1, and flash lines 15 and 14 equal `cpuAddr[15]` and `cpuAddr[14]`. `pageBit128` and `m1N` then have no effect.
- R8: A stored byte with bit 3 set selects 32-page mode. The page number {bits 6,5,2,1,0} drives flash lines 18..14. Examples: 0xA8 gives page 8, 0xC8 gives page 16, 0xEF gives page 31, and 0xB8 gives page 8 with writing permitted.
- R9: `ulaBlock` is 1 exactly when `iorqN`=0 and either `cpuAddr[2]`=0 or `cpuAddr[5]`=0.
- R10: `flashCeN` is 0 exactly when `mreqN`=0 and the ROM is enabled.
- R11: Flash lines 13..0 always equal `cpuAddr[13:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; port writes are sampled on its rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| cpuAddr | input | 16 | CPU address bus |
| cpuData | input | 8 | CPU data bus |
| iorqN | input | 1 | Active-low I/O request |
| mreqN | input | 1 | Active-low memory request |
| wrN | input | 1 | Active-low write strobe |
| m1N | input | 1 | Active-low opcode-fetch cycle |
| extSelN | input | 1 | Active-low external port select, used when USE_EXT_SEL=1 |
| pageBit128 | input | 1 | Bit 4 of the 128K paging port |
| exromMode | input | 1 | EXROM mode pin |
| flashAddr | output | 19 | Flash address lines |
| flashCeN | output | 1 | Active-low flash chip enable |
| flashWeN | output | 1 | Active-low flash write enable |
| romDisable | output | 1 | ROM-disable to the expansion slot, 1 = ROM off |
| ulaBlock | output | 1 | 1 = keep the video chip off the I/O bus |

## Verification
The in-RTL properties hold on every cycle. They cover:
- the stored byte holding still when no port write is accepted;
- the sticky flag never falling without a reset;
- the ROM being disabled only with the flag set;
- a write strobe reaching the flash only with the permit bit set;
- EXROM forcing line 16;
- the video-suppress line staying low outside I/O cycles.

The actual line mapping can only be shown by the directed scenarios. These cover each page number per mode, the /M1 and 128K substitutions, the 32-page examples, rejected addresses and read cycles, and the first-write enable sequence.

// File: rtl/rom_pager_pkg.sv
package rom_pager_pkg;

  // Strobes from the bus decoder to the paging datapath.
  typedef struct packed {
    logic portWr;   // accepted write to the paging port this cycle
    logic memCycle; // memory request active
    logic memWr;    // memory write strobe active
  } pager_strobes_t;

  // Field positions inside the stored paging byte.
  localparam int unsigned PG_B0   = 0;
  localparam int unsigned PG_B1   = 1;
  localparam int unsigned PG_B2   = 2;
  localparam int unsigned PG_WIDE = 3;
  localparam int unsigned PG_WEN  = 4;
  localparam int unsigned PG_SW128 = 5;
  localparam int unsigned PG_TRAP = 6;
  localparam int unsigned PG_ROM  = 7;

endpackage

// File: rtl/rom_pager_decode.sv
module rom_pager_decode
  import rom_pager_pkg::*;
#(
  parameter logic [7:0] PORT_ADDR   = 8'hD0,
  parameter bit         USE_EXT_SEL = 1'b0
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [7:0]     ioAddr,
  input  logic           iorqN,
  input  logic           mreqN,
  input  logic           wrN,
  input  logic           extSelN,
  output pager_strobes_t strobes,
  output logic           ulaBlock
);

  logic fullHit;
  logic extHit;

  // Full 8-bit decode of the port, or external select with A1/A0 qualification.
  assign fullHit = (ioAddr == PORT_ADDR) && !iorqN;
  assign extHit  = !extSelN && (ioAddr[1:0] == PORT_ADDR[1:0]);

  always_comb begin
    strobes.portWr   = (USE_EXT_SEL ? extHit : fullHit) && !wrN;
    strobes.memCycle = !mreqN;
    strobes.memWr    = !mreqN && !wrN;
  end

  // Keep the video chip away from the 0xD0..0xD3 group.
  assign ulaBlock = !iorqN && (!ioAddr[2] || !ioAddr[5]);

  p_ula_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    iorqN |-> !ulaBlock);

  p_wr_needs_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.portWr |-> !wrN);

endmodule

// File: rtl/rom_pager_bank.sv
module rom_pager_bank
  import rom_pager_pkg::*;
#(
  parameter bit          BIG_FLASH = 1'b1,
  parameter int unsigned WINDOW_AW = 14,
  parameter int unsigned FLASH_AW  = BIG_FLASH ? WINDOW_AW + 5 : WINDOW_AW + 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  pager_strobes_t      strobes,
  input  logic [7:0]          cpuData,
  input  logic [15:0]         cpuAddr,
  input  logic                m1N,
  input  logic                pageBit128,
  input  logic                exromMode,
  output logic [FLASH_AW-1:0] flashAddr,
  output logic                flashCeN,
  output logic                flashWeN,
  output logic                romDisable
);

  localparam int unsigned PAGE_BITS = FLASH_AW - WINDOW_AW;

  logic [7:0]           pageReg;
  logic                 firstSeen;
  logic                 wideMode;
  logic                 romOn;
  logic [PAGE_BITS-1:0] pageLines;
  logic                 line14;
  logic                 line15;
  logic                 line16;

  // Paging byte and sticky first-write flag.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageReg   <= '0;
      firstSeen <= 1'b0;
    end else if (strobes.portWr) begin
      pageReg   <= cpuData;
      firstSeen <= 1'b1;
    end
  end

  assign wideMode   = BIG_FLASH && pageReg[PG_WIDE];
  assign romDisable = !pageReg[PG_ROM] && firstSeen;
  assign romOn      = !romDisable;

  // Line 14/15/16 choice for the eight-page arrangement.
  always_comb begin
    if (exromMode) begin
      line14 = cpuAddr[14];
      line15 = cpuAddr[15];
      line16 = 1'b1;
    end else begin
      line14 = pageReg[PG_SW128] ? pageBit128 : pageReg[PG_B0];
      line15 = pageReg[PG_TRAP]  ? m1N        : pageReg[PG_B1];
      line16 = pageReg[PG_B2];
    end
  end

  generate
    if (BIG_FLASH) begin : g_wide
      logic [4:0] widePage;
      assign widePage = {pageReg[PG_TRAP], pageReg[PG_SW128],
                         pageReg[PG_B2], pageReg[PG_B1], pageReg[PG_B0]};
      always_comb begin
        if (wideMode && !exromMode) begin
          pageLines = widePage;
        end else if (wideMode) begin
          pageLines = {widePage[4:3], line16, line15, line14};
        end else begin
          pageLines = {2'b00, line16, line15, line14};
        end
      end
    end else begin : g_narrow
      assign pageLines = {line16, line15, line14};
    end
  endgenerate

  assign flashAddr = {pageLines, cpuAddr[WINDOW_AW-1:0]};
  assign flashCeN  = !(strobes.memCycle && romOn);
  assign flashWeN  = !(strobes.memWr && romOn && pageReg[PG_WEN]);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.portWr |=> $stable(pageReg));

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    firstSeen |=> firstSeen);

  p_off_needs_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
    romDisable |-> firstSeen);

  p_write_permit_r4: assert property (@(posedge clk) disable iff (!rstN)
    !flashWeN |-> (pageReg[PG_WEN] && !flashCeN));

  p_exrom_top_r7: assert property (@(posedge clk) disable iff (!rstN)
    (exromMode && !wideMode) |-> flashAddr[WINDOW_AW+2]);

  p_ce_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    !flashCeN |-> (strobes.memCycle && !romDisable));

endmodule

// File: rtl/rom_pager.sv
module rom_pager
  import rom_pager_pkg::*;
#(
  parameter logic [7:0]  PORT_ADDR   = 8'hD0,
  parameter bit          USE_EXT_SEL = 1'b0,
  parameter bit          BIG_FLASH   = 1'b1,
  parameter int unsigned WINDOW_AW   = 14,
  parameter int unsigned FLASH_AW    = BIG_FLASH ? WINDOW_AW + 5 : WINDOW_AW + 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [15:0]         cpuAddr,
  input  logic [7:0]          cpuData,
  input  logic                iorqN,
  input  logic                mreqN,
  input  logic                wrN,
  input  logic                m1N,
  input  logic                extSelN,
  input  logic                pageBit128,
  input  logic                exromMode,
  output logic [FLASH_AW-1:0] flashAddr,
  output logic                flashCeN,
  output logic                flashWeN,
  output logic                romDisable,
  output logic                ulaBlock
);

  pager_strobes_t strobes;

  rom_pager_decode #(
    .PORT_ADDR  (PORT_ADDR),
    .USE_EXT_SEL(USE_EXT_SEL)
  ) u_decode (
    .clk     (clk),
    .rstN    (rstN),
    .ioAddr  (cpuAddr[7:0]),
    .iorqN   (iorqN),
    .mreqN   (mreqN),
    .wrN     (wrN),
    .extSelN (extSelN),
    .strobes (strobes),
    .ulaBlock(ulaBlock)
  );

  rom_pager_bank #(
    .BIG_FLASH(BIG_FLASH),
    .WINDOW_AW(WINDOW_AW),
    .FLASH_AW (FLASH_AW)
  ) u_bank (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .cpuData   (cpuData),
    .cpuAddr   (cpuAddr),
    .m1N       (m1N),
    .pageBit128(pageBit128),
    .exromMode (exromMode),
    .flashAddr (flashAddr),
    .flashCeN  (flashCeN),
    .flashWeN  (flashWeN),
    .romDisable(romDisable)
  );

endmodule

// File: tb/rom_pager_bench.sv
`timescale 1ns/1ps
module rom_pager_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuData = '0;
  logic        iorqN = 1'b1, mreqN = 1'b1, wrN = 1'b1, m1N = 1'b1;
  logic        extSelN = 1'b1, pageBit128 = 1'b0, exromMode = 1'b0;
  logic [18:0] flashAddr;
  logic        flashCeN, flashWeN, romDisable, ulaBlock;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rom_pager u_rom_pager (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuData(cpuData),
    .iorqN(iorqN), .mreqN(mreqN), .wrN(wrN), .m1N(m1N), .extSelN(extSelN),
    .pageBit128(pageBit128), .exromMode(exromMode), .flashAddr(flashAddr),
    .flashCeN(flashCeN), .flashWeN(flashWeN), .romDisable(romDisable),
    .ulaBlock(ulaBlock)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    iorqN = 1'b1; mreqN = 1'b1; wrN = 1'b1;
  endtask

  task automatic ioWrite(input logic [7:0] port, input logic [7:0] val, input logic asRead);
    @(negedge clk);
    cpuAddr = {8'h00, port}; cpuData = val; iorqN = 1'b0; wrN = asRead;
    @(posedge clk);
    idle();
  endtask

  // Present a memory read at addr and settle before sampling.
  task automatic memRead(input logic [15:0] addr);
    @(negedge clk);
    cpuAddr = addr; mreqN = 1'b0; wrN = 1'b1;
    #1;
  endtask

  task automatic t_reset();
    memRead(16'h0000);
    chk("R1 romDisable", romDisable, 0);
    chk("R1 page lines", flashAddr[18:14], 0);
    chk("R1 weN", flashWeN, 1);
    chk("R10 ceN after reset", flashCeN, 0);
    idle();
  endtask

  task automatic t_first_write();
    ioWrite(8'hD0, 8'h00, 1'b0);
    memRead(16'h0000);
    chk("R3 disabled after first write", romDisable, 1);
    chk("R10 ceN while disabled", flashCeN, 1);
    ioWrite(8'hD0, 8'h80, 1'b0);
    memRead(16'h0000);
    chk("R3 enabled with bit7", romDisable, 0);
    idle();
  endtask

  task automatic t_ignored();
    ioWrite(8'hD0, 8'h84, 1'b0);
    ioWrite(8'hD1, 8'h00, 1'b0);
    ioWrite(8'h50, 8'h00, 1'b0);
    ioWrite(8'hD0, 8'h00, 1'b1); // read cycle
    memRead(16'h0000);
    chk("R2 other ports/reads ignored: rom", romDisable, 0);
    chk("R2 other ports/reads ignored: page", flashAddr[18:14], 5'h04);
    idle();
  endtask

  task automatic t_page_and_low();
    ioWrite(8'hD0, 8'h85, 1'b0);
    memRead(16'h1234);
    chk("R5 line14 from bit0", flashAddr[14], 1);
    chk("R6 line15 from bit1", flashAddr[15], 0);
    chk("R11 low lines", flashAddr[13:0], 14'h1234);
    chk("R8 narrow mode top zero", flashAddr[18:16], 3'b001);
    idle();
  endtask

  task automatic t_write_protect();
    ioWrite(8'hD0, 8'h80, 1'b0);
    @(negedge clk); mreqN = 1'b0; wrN = 1'b0; #1;
    chk("R4 protected", flashWeN, 1);
    idle();
    ioWrite(8'hD0, 8'h90, 1'b0);
    @(negedge clk); mreqN = 1'b1; wrN = 1'b0; #1;
    chk("R4 no mreq no write", flashWeN, 1);
    @(negedge clk); mreqN = 1'b0; wrN = 1'b0; #1;
    chk("R4 permitted", flashWeN, 0);
    idle();
  endtask

  task automatic t_sw128();
    ioWrite(8'hD0, 8'hA0, 1'b0);
    pageBit128 = 1'b1;
    memRead(16'h0000);
    chk("R5 line14 follows 128K bit high", flashAddr[14], 1);
    pageBit128 = 1'b0; #1;
    chk("R5 line14 follows 128K bit low", flashAddr[14], 0);
    idle();
  endtask

  task automatic t_trap();
    ioWrite(8'hD0, 8'hC2, 1'b0);
    m1N = 1'b0;
    memRead(16'h3D00);
    chk("R6 fetch page", flashAddr[16:14], 3'b000);
    m1N = 1'b1; #1;
    chk("R6 data page", flashAddr[16:14], 3'b010);
    idle();
  endtask

  task automatic t_exrom();
    ioWrite(8'hD0, 8'hE0, 1'b0);
    exromMode = 1'b1; pageBit128 = 1'b0; m1N = 1'b0;
    memRead(16'hC000);
    chk("R7 exrom C000", flashAddr[16:14], 3'b111);
    cpuAddr = 16'h4000; #1;
    chk("R7 exrom 4000", flashAddr[16:14], 3'b101);
    exromMode = 1'b0; m1N = 1'b1;
    idle();
  endtask

  task automatic t_wide();
    ioWrite(8'hD0, 8'hA8, 1'b0);
    memRead(16'h0000);
    chk("R8 0xA8 page 8", flashAddr[18:14], 5'd8);
    ioWrite(8'hD0, 8'hC8, 1'b0);
    memRead(16'h0000);
    chk("R8 0xC8 page 16", flashAddr[18:14], 5'd16);
    ioWrite(8'hD0, 8'hEF, 1'b0);
    memRead(16'h0000);
    chk("R8 0xEF page 31", flashAddr[18:14], 5'd31);
    ioWrite(8'hD0, 8'hB8, 1'b0);
    @(negedge clk); cpuAddr = 16'h0000; mreqN = 1'b0; wrN = 1'b0; #1;
    chk("R8 0xB8 page 8", flashAddr[18:14], 5'd8);
    chk("R8 0xB8 write permitted", flashWeN, 0);
    idle();
  endtask

  task automatic t_ula();
    @(negedge clk); iorqN = 1'b0; cpuAddr = 16'h00FE; #1;
    chk("R9 port FE", ulaBlock, 0);
    cpuAddr = 16'h00FB; #1;
    chk("R9 A2 low", ulaBlock, 1);
    cpuAddr = 16'h00DF; #1;
    chk("R9 A5 low", ulaBlock, 1);
    iorqN = 1'b1; #1;
    chk("R9 no iorq", ulaBlock, 0);
    idle();
  endtask

  task automatic t_rereset();
    ioWrite(8'hD0, 8'h07, 1'b0);
    @(negedge clk); rstN = 1'b0; #1;
    chk("R1 reset clears disable", romDisable, 0);
    chk("R1 reset clears page", flashAddr[18:14], 0);
    @(negedge clk); rstN = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_first_write();
    t_ignored();
    t_page_and_low();
    t_write_protect();
    t_sw128();
    t_trap();
    t_exrom();
    t_wide();
    t_ula();
    t_rereset();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule